// File: doc/BRIEF.md
# Multi-Channel Register Window Decoder

This block sits between a host register bus and eight serial channel cores. The host address space covers 8 KB, counted from a base that sits upstream of this block. It is cut into eight 1 KB windows, one per channel. Each window has three parts:

- a local register span, forwarded to the channel core with a one-hot select and read/write strobes;
- one shared control word, which can be reached from every window;
- an unmapped remainder.

The shared control word holds four per-channel bit vectors: x8 sampling, x4 sampling, sleep, and a self-clearing reset pulse. A write that arrives through window n can only change bit n of each vector. A channel driver therefore cannot disturb a neighbour's clocking, power state or reset.

Requests use a valid/ready handshake, and read responses use a second valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A read's response appears on the next cycle. It is held stable until `rsp_ready` is seen high. While a response is waiting and `rsp_ready` is low, `req_ready` is low, so the host is back-pressured. Writes produce no response. The bus is 32 bits wide. Address bits [1:0] are ignored, and the byte enables choose the lanes, so 8, 16, 24 and 32-bit accesses all work.

Top module: `wdec_top`

## Requirements
- R1: After reset, `sample_x8`, `sample_x4`, `sleep_en`, `rst_pulse`, `rsp_valid` and `ch_sel` are all zero.
- R2: Address bits [12:10] give the channel. For a window offset below 0x080, an accepted request asserts only `ch_sel[n]` in the same cycle, together with `ch_wr` (write) or `ch_rd` (read). In that cycle `ch_word` carries offset bits [6:2], and `ch_be` and `ch_wdata` carry the request's byte enables and data.
- R3: A read of the local span returns channel n's 32-bit slice of `ch_rdata` as it was in the acceptance cycle. The response is on `rsp_rdata` with `rsp_valid` high in the next cycle.
- R4: The shared control word sits at offset 0x080 (bytes 0x080–0x083) in every window. Reading it through any window returns `sample_x8` in byte 0, `sample_x4` in byte 1, `rst_pulse` in byte 2 and `sleep_en` in byte 3.
- R5: A write to the shared word through window n sets bit n of each written vector to data bit 8·lane+n. Every other channel's bits stay unchanged.
- R6: Only lanes whose byte enable is 1 are updated. Lanes 0, 1 and 3 hold their bit when their enable is 0, and lane 2 produces no pulse.
- R7: Writing 1 to channel n's reset bit raises `rst_pulse[n]` for exactly the one cycle that follows the accepting edge. The bit then reads back as 0.
- R8: Offsets 0x084–0x3FF read as zero. A write there changes no state and raises no `ch_sel`.
- R9: `req_ready` is low only while a response is pending and `rsp_ready` is low. A pending response keeps `rsp_rdata` stable, and a request offered during that time is not taken.
- R10: Reads never change `sample_x8`, `sample_x4` or `sleep_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address within the 8 KB space |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte lane enables |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read response data |
| ch_sel | output | 8 | One-hot channel local-register select |
| ch_wr | output | 1 | Local write strobe |
| ch_rd | output | 1 | Local read strobe |
| ch_word | output | 5 | Word index inside the local span |
| ch_be | output | 4 | Byte enables to the channel |
| ch_wdata | output | 32 | Write data to the channel |
| ch_rdata | input | 256 | Read data of all channels, channel n at [32n+31:32n] |
| sample_x8 | output | 8 | Per-channel x8 sampling enable |
| sample_x4 | output | 8 | Per-channel x4 sampling enable |
| sleep_en | output | 8 | Per-channel sleep enable |
| rst_pulse | output | 8 | Per-channel one-cycle reset pulse |

## Verification
The bench writes all-ones words to the shared word through a chosen window. A decoder that did not enforce per-channel ownership would set every channel's bits, or the wrong one, and the bench would see foreign bits change. Single-lane writes with partial byte enables catch a design that ignores the enables and changes or pulses lanes it was not given. Writes to the top of the unmapped range catch a decoder that aliases those offsets onto the shared word or the local span. A stalled response with a request offered behind it catches a design that drops data or accepts the request while back-pressured. Reading the reset byte one cycle after a pulse catches a pulse that lasts too long or never clears.

// File: rtl/wdec_pkg.sv
package wdec_pkg;
  localparam int BUS_W   = 32;
  localparam int LANES   = BUS_W / 8;

  typedef enum logic [1:0] {
    RGN_NONE   = 2'd0,
    RGN_LOCAL  = 2'd1,
    RGN_SHARED = 2'd2
  } region_e;
endpackage

// File: rtl/wdec_addr_decode.sv
module wdec_addr_decode
  import wdec_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int WIN_W      = 10,
  parameter int LOCAL_SPAN = 128,
  parameter int SHARED_OFS = 128,
  localparam int CH_W      = ADDR_W - WIN_W,
  localparam int WORD_W    = $clog2(LOCAL_SPAN) - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [CH_W-1:0]   ch,
  output logic [WORD_W-1:0] word
);
  localparam logic [WIN_W-3:0] SHARED_WORD = (WIN_W-2)'(SHARED_OFS / 4);

  logic [WIN_W-1:0] ofs;
  logic [1:0]       unused_lsb;

  assign ofs        = addr[WIN_W-1:0];
  assign ch         = addr[ADDR_W-1:WIN_W];
  assign word       = ofs[WORD_W+1:2];
  assign unused_lsb = addr[1:0];

  always_comb begin
    if (ofs < WIN_W'(LOCAL_SPAN))             region = RGN_LOCAL;
    else if (ofs[WIN_W-1:2] == SHARED_WORD)   region = RGN_SHARED;
    else                                      region = RGN_NONE;
  end
endmodule

// File: rtl/wdec_shared_regs.sv
module wdec_shared_regs
  import wdec_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [LANES-1:0]  be,
  output logic [NUM_CH-1:0] x8_q,
  output logic [NUM_CH-1:0] x4_q,
  output logic [NUM_CH-1:0] sleep_q,
  output logic [NUM_CH-1:0] pulse_q
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    logic owner;
    assign owner = wr_en && (wr_ch == CH_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        x8_q[i]    <= 1'b0;
        x4_q[i]    <= 1'b0;
        sleep_q[i] <= 1'b0;
        pulse_q[i] <= 1'b0;
      end else begin
        if (owner && be[0]) x8_q[i]    <= wdata[i];
        if (owner && be[1]) x4_q[i]    <= wdata[8+i];
        if (owner && be[3]) sleep_q[i] <= wdata[24+i];
        pulse_q[i] <= owner && be[2] && wdata[16+i];
      end
    end
  end
endmodule

// File: rtl/wdec_rsp_stage.sv
module wdec_rsp_stage
  import wdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_take,
  input  logic [BUS_W-1:0] rd_data,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [BUS_W-1:0] out_data,
  output logic             in_ready
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (rd_take) begin
      out_valid <= 1'b1;
      out_data  <= rd_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wdec_top.sv
module wdec_top
  import wdec_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int WIN_W      = 10,
  parameter int LOCAL_SPAN = 128,
  parameter int SHARED_OFS = 128,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int ADDR_W    = WIN_W + CH_W,
  localparam int WORD_W    = $clog2(LOCAL_SPAN) - 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [BUS_W-1:0]        req_wdata,
  input  logic [LANES-1:0]        req_be,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [BUS_W-1:0]        rsp_rdata,
  output logic [NUM_CH-1:0]       ch_sel,
  output logic                    ch_wr,
  output logic                    ch_rd,
  output logic [WORD_W-1:0]       ch_word,
  output logic [LANES-1:0]        ch_be,
  output logic [BUS_W-1:0]        ch_wdata,
  input  logic [NUM_CH*BUS_W-1:0] ch_rdata,
  output logic [NUM_CH-1:0]       sample_x8,
  output logic [NUM_CH-1:0]       sample_x4,
  output logic [NUM_CH-1:0]       sleep_en,
  output logic [NUM_CH-1:0]       rst_pulse
);
  region_e          region;
  logic [CH_W-1:0]  ch;
  logic             take;
  logic             local_hit;
  logic             shared_wr;
  logic [BUS_W-1:0] rd_mux;
  logic [BUS_W-1:0] shared_word;

  wdec_addr_decode #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W),
    .LOCAL_SPAN(LOCAL_SPAN), .SHARED_OFS(SHARED_OFS)
  ) u_dec (
    .addr(req_addr), .region(region), .ch(ch), .word(ch_word)
  );

  assign take      = req_valid && req_ready;
  assign local_hit = take && (region == RGN_LOCAL);
  assign shared_wr = take && req_write && (region == RGN_SHARED);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign ch_sel[i] = local_hit && (ch == CH_W'(i));
  end

  assign ch_wr    = local_hit && req_write;
  assign ch_rd    = local_hit && !req_write;
  assign ch_be    = req_be;
  assign ch_wdata = req_wdata;

  wdec_shared_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(shared_wr), .wr_ch(ch), .wdata(req_wdata), .be(req_be),
    .x8_q(sample_x8), .x4_q(sample_x4), .sleep_q(sleep_en), .pulse_q(rst_pulse)
  );

  assign shared_word = {8'(sleep_en), 8'(rst_pulse), 8'(sample_x4), 8'(sample_x8)};

  always_comb begin
    case (region)
      RGN_LOCAL:  rd_mux = ch_rdata[ch*BUS_W +: BUS_W];
      RGN_SHARED: rd_mux = shared_word;
      default:    rd_mux = '0;
    endcase
  end

  wdec_rsp_stage u_rsp (
    .clk(clk), .rst_n(rst_n),
    .rd_take(take && !req_write), .rd_data(rd_mux),
    .out_ready(rsp_ready), .out_valid(rsp_valid), .out_data(rsp_rdata),
    .in_ready(req_ready)
  );
endmodule

// File: rtl/wdec_checker.sv
module wdec_checker #(
  parameter int NUM_CH     = 8,
  parameter int WIN_W      = 10,
  parameter int SHARED_OFS = 128,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int ADDR_W    = WIN_W + CH_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic [NUM_CH-1:0] ch_sel,
  input logic [NUM_CH-1:0] sample_x8,
  input logic [NUM_CH-1:0] sample_x4,
  input logic [NUM_CH-1:0] sleep_en,
  input logic [NUM_CH-1:0] rst_pulse
);
  logic              acc;
  logic              gw;
  logic              beyond;
  logic [NUM_CH-1:0] keep;

  assign acc    = req_valid && req_ready;
  assign gw     = acc && req_write && (req_addr[WIN_W-1:2] == (WIN_W-2)'(SHARED_OFS / 4));
  assign beyond = req_addr[WIN_W-1:0] >= WIN_W'(SHARED_OFS + 4);
  assign keep   = ~(NUM_CH'(1) << req_addr[ADDR_W-1:WIN_W]);

  a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));

  a_r5_foreign_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    gw |=> (((sample_x8 ^ $past(sample_x8)) | (sample_x4 ^ $past(sample_x4)) |
             (sleep_en ^ $past(sleep_en))) & $past(keep)) == '0);

  a_r7_pulse_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rst_pulse) && !gw) |=> (rst_pulse == '0));

  a_r7_pulse_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
    gw |=> ((rst_pulse & $past(keep)) == '0));

  a_r8_unmapped_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && beyond) |-> (ch_sel == '0));

  a_r10_state_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !gw |=> ($stable(sample_x8) && $stable(sample_x4) && $stable(sleep_en)));

  a_r9_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  a_r9_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (rsp_valid && !rsp_ready));
endmodule

bind wdec_top wdec_checker #(
  .NUM_CH(NUM_CH), .WIN_W(WIN_W), .SHARED_OFS(SHARED_OFS)
) u_wdec_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .ch_sel(ch_sel),
  .sample_x8(sample_x8), .sample_x4(sample_x4), .sleep_en(sleep_en),
  .rst_pulse(rst_pulse)
);

// File: tb/test_wdec_top.sv
`timescale 1ns/1ps
module test_wdec_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [12:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic [3:0]   req_be = '0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [31:0]  rsp_rdata;
  logic [7:0]   ch_sel;
  logic         ch_wr, ch_rd;
  logic [4:0]   ch_word;
  logic [3:0]   ch_be;
  logic [31:0]  ch_wdata;
  logic [255:0] ch_rdata = '0;
  logic [7:0]   sample_x8, sample_x4, sleep_en, rst_pulse;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] m8 = '0, m4 = '0, msl = '0, mpulse = '0;

  always #2.5 clk = ~clk;

  wdec_top i_wdec_top (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int region_of(input logic [9:0] ofs);
    if (ofs < 10'h080) return 1;
    if (ofs[9:2] == 8'h20) return 2;
    return 0;
  endfunction

  task automatic check_state(input string req);
    chk({req, " x8"}, {24'h0, sample_x8}, {24'h0, m8});
    chk({req, " x4"}, {24'h0, sample_x4}, {24'h0, m4});
    chk({req, " sleep"}, {24'h0, sleep_en}, {24'h0, msl});
  endtask

  task automatic do_op(input bit wr, input logic [2:0] ch, input logic [9:0] ofs,
                       input logic [3:0] be, input logic [31:0] wd);
    int rg;
    logic [31:0] exp_rd;
    @(negedge clk);
    chk("R7 pulse cleared", {24'h0, rst_pulse}, 32'h0);
    mpulse = '0;
    for (int k = 0; k < 8; k++) ch_rdata[k*32 +: 32] = $urandom;
    req_valid = 1'b1; req_write = wr; req_addr = {ch, ofs};
    req_be = be; req_wdata = wd;
    #1;
    rg = region_of(ofs);
    chk("R2/R8 ch_sel", {24'h0, ch_sel}, (rg == 1) ? (32'h1 << ch) : 32'h0);
    if (rg == 1) begin
      chk("R2 strobes", {30'h0, ch_wr, ch_rd}, {30'h0, wr, !wr});
      chk("R2 word", {27'h0, ch_word}, {27'h0, ofs[6:2]});
      chk("R2 be/data", {ch_be, ch_wdata[27:0]}, {be, wd[27:0]});
    end
    exp_rd = (rg == 1) ? ch_rdata[ch*32 +: 32] :
             (rg == 2) ? {msl, mpulse, m4, m8} : 32'h0;
    @(negedge clk);
    req_valid = 1'b0;
    if (wr && rg == 2) begin
      if (be[0]) m8[ch]  = wd[ch];
      if (be[1]) m4[ch]  = wd[8+ch];
      if (be[3]) msl[ch] = wd[24+ch];
      if (be[2] && wd[16+ch]) mpulse[ch] = 1'b1;
    end
    check_state("R5/R6/R8/R10");
    chk("R7 pulse", {24'h0, rst_pulse}, {24'h0, mpulse});
    if (wr) chk("R9 no write rsp", {31'h0, rsp_valid}, 32'h0);
    else begin
      chk("R9 rsp valid", {31'h0, rsp_valid}, 32'h1);
      chk(rg == 1 ? "R3 local read" : (rg == 2 ? "R4 shared read" : "R8 unmapped read"),
          rsp_rdata, exp_rd);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {sample_x8, sample_x4, sleep_en, rst_pulse}, 32'h0);
    chk("R1 reset rsp", {30'h0, rsp_valid, |ch_sel}, 32'h0);
    rst_n = 1'b1;

    // R5: full-width all-ones through window 2 touches only bit 2
    do_op(1'b1, 3'd2, 10'h080, 4'hF, 32'hFFFF_FFFF);
    chk("R5 only own bit", {sample_x8, sample_x4, sleep_en, 8'h0}, {8'h04, 8'h04, 8'h04, 8'h0});
    // R6: byte-only write through window 5
    do_op(1'b1, 3'd5, 10'h081, 4'b0001, 32'hFFFF_FFFF);
    chk("R6 single lane", {sample_x8, sample_x4, sleep_en, rst_pulse}, {8'h24, 8'h04, 8'h04, 8'h00});
    // R7: pulse read back as 0 via window 6
    do_op(1'b1, 3'd6, 10'h082, 4'b0100, 32'h00FF_0000);
    do_op(1'b0, 3'd6, 10'h080, 4'hF, 32'h0);
    chk("R7 reads zero", {24'h0, rsp_rdata[23:16]}, 32'h0);
    // R8: top of unmapped range
    do_op(1'b1, 3'd7, 10'h3FC, 4'hF, 32'hFFFF_FFFF);
    do_op(1'b0, 3'd7, 10'h3FC, 4'hF, 32'h0);
    do_op(1'b0, 3'd0, 10'h084, 4'hF, 32'h0);
    // R4: shared word via window 7
    do_op(1'b0, 3'd7, 10'h080, 4'hF, 32'h0);
    chk("R4 shared layout", rsp_rdata, 32'h0400_0424);

    // R9: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    do_op(1'b0, 3'd3, 10'h010, 4'hF, 32'h0);
    held = rsp_rdata;
    req_valid = 1'b1; req_write = 1'b1; req_addr = {3'd1, 10'h080};
    req_be = 4'hF; req_wdata = 32'hFFFF_FFFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 ready low", {31'h0, req_ready}, 32'h0);
      chk("R9 rsp held", rsp_rdata, held);
    end
    req_valid = 1'b0;
    check_state("R9 stalled request not taken");
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 rsp drained", {31'h0, rsp_valid}, 32'h0);

    for (int n = 0; n < 400; n++) begin
      logic [9:0] ofs;
      case ($urandom % 3)
        0: ofs = 10'($urandom % 128);
        1: ofs = 10'h080 | 10'($urandom % 4);
        default: ofs = 10'h084 + 10'($urandom % 10'h37C);
      endcase
      do_op(1'($urandom), 3'($urandom), ofs, 4'($urandom), $urandom);
    end

    @(negedge clk);
    chk("R7 final clear", {24'h0, rst_pulse}, 32'h0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule